// File: doc/BRIEF.md
# Shared-Pool Queue Admission Controller

This block decides whether a packet may enter one egress buffer pool that several queues share. Space is counted in whole cells. Each queue owns a guaranteed region. Beyond that region it competes for a common shared region. The shared cells a queue may hold are capped by a dynamic limit: that queue's alpha factor times the number of shared cells that are still free at the moment of the request. A queue that fills up therefore sees its own limit shrink, and several congested queues settle into a fair split.

An enqueue request carries a queue index and a length in cells. The decision is reported one clock later. An accepted packet is charged at once. A release returns cells from a queue when its packets leave. Configuration sets the shared pool size, a total guaranteed budget that is split among queues by per-queue fractions, and a 4-bit alpha code per queue. The per-queue guaranteed and shared counts and the free shared count are visible at the outputs.

Top module: `dtq_admit`

## Requirements
- R1: While reset is held and on the first cycle after it, every per-queue guaranteed and shared count reads zero, `res_valid` is low, and `pool_free` equals `cfg_pool_cells`.
- R2: `res_valid` is high in exactly the cycle after a cycle with `enq_valid` high. `res_accept` gives that request's decision, where 1 means admitted.
- R3: A queue's cells are charged to its guaranteed region until that region holds its full allotment. Shared cells are charged only after that.
- R4: When a packet only partly fits in the remaining guaranteed room, the guaranteed region is filled and the rest goes to the shared region on the same clock edge.
- R5: Let free be the pool size minus all shared cells in use, and let need be the shared cells the packet requires. A packet with need > 0 is admitted only if need ≤ free and (queue shared cells + need) ≤ alpha × free.
- R6: An alpha code c scales by 2^(c−7). Codes below 7 shift free right by 7−c, codes 7 to 10 shift it left by c−7, and codes above 10 behave as 10.
- R7: A packet is admitted whole or not at all. A dropped packet changes no count.
- R8: A release for a queue first returns shared cells, then guaranteed cells. A release larger than the queue holds leaves both counts at zero and never wraps.
- R9: Queue q's guaranteed allotment is floor(total × frac_q / 256), using field q of `cfg_guar_frac` (bits 8q+7:8q). The cells lost to rounding are added to queue 0.
- R10: With alpha code 7 and no other queue in the shared region, one queue fills exactly half of the shared pool and then drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_pool_cells | input | 12 | Shared pool size in cells |
| cfg_guar_total | input | 12 | Guaranteed budget split among queues |
| cfg_guar_frac | input | 32 | Per-queue fraction of the budget, 8 bits each, in units of 1/256 |
| cfg_alpha | input | 16 | Per-queue alpha code, 4 bits each, queue q at bits 4q+3:4q |
| enq_valid | input | 1 | Enqueue request present |
| enq_qid | input | 2 | Target queue of the request |
| enq_len | input | 6 | Packet length in cells, at least 1 |
| rel_valid | input | 1 | Release present |
| rel_qid | input | 2 | Queue that returns cells |
| rel_len | input | 6 | Cells returned |
| res_valid | output | 1 | Decision present |
| res_accept | output | 1 | 1 = admitted, 0 = dropped |
| occ_guar | output | 48 | Guaranteed cells held, 12 bits per queue |
| occ_shared | output | 48 | Shared cells held, 12 bits per queue |
| pool_free | output | 12 | Shared cells not in use |

## Verification
The assertions assume that the configuration inputs hold steady outside reset. They also assume that the per-queue fractions sum to at most 256 and that a request never has zero length. The bound checks on guaranteed counts and pool use depend on these assumptions. The bench keeps to them: it applies each configuration while reset is asserted, it drives only lengths from 1 to 63, and it uses fraction sets whose totals stay under the limit. Same-queue enqueue and release in one cycle are legal, and the bench does drive them. The guaranteed-first and no-wrap properties skip only those cycles.

// File: rtl/dtq_pkg.sv
// Shared constants and helpers for the shared-pool admission controller.
// Assumes the alpha code is 4 bits wide and that code 7 means a factor of one.
package dtq_pkg;
    localparam int ALPHA_W     = 4;
    localparam int ALPHA_UNITY = 7;
    localparam int ALPHA_TOP   = 10;

    // Saturate an alpha code at the largest supported factor.
    function automatic logic [ALPHA_W-1:0] alpha_clamp(input logic [ALPHA_W-1:0] code);
        return (code > ALPHA_W'(ALPHA_TOP)) ? ALPHA_W'(ALPHA_TOP) : code;
    endfunction
endpackage

// File: rtl/dtq_guar_split.sv
// Splits a guaranteed-cell budget among queues by 1/2^FRAC_W fractions.
// Each share is rounded down, and the cells lost to rounding go to queue 0.
// Assumes the fractions sum to at most 2^FRAC_W. Otherwise no remainder is added.
module dtq_guar_split #(
    parameter int NUM_Q  = 4,
    parameter int CNT_W  = 12,
    parameter int FRAC_W = 8,
    localparam int PROD_W = CNT_W + FRAC_W,
    localparam int SUM_W  = CNT_W + $clog2(NUM_Q) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CNT_W-1:0]        total,
    input  logic [NUM_Q*FRAC_W-1:0] frac,
    output logic [NUM_Q*CNT_W-1:0]  mins
);
    logic [CNT_W-1:0] share [NUM_Q];
    logic [SUM_W-1:0] share_sum;
    logic [CNT_W-1:0] leftover;

    for (genvar q = 0; q < NUM_Q; q++) begin : g_share
        logic [PROD_W-1:0] prod;
        // Scale the budget by this queue's fraction, dropping the fraction bits.
        assign prod     = PROD_W'(total) * PROD_W'(frac[q*FRAC_W +: FRAC_W]);
        assign share[q] = prod[PROD_W-1:FRAC_W];
        if (q == 0) begin : g_first
            assign mins[0 +: CNT_W] = share[0] + leftover;
        end else begin : g_rest
            assign mins[q*CNT_W +: CNT_W] = share[q];
        end
    end

    // Add up the rounded shares and find the unassigned remainder.
    always_comb begin
        share_sum = '0;
        for (int q = 0; q < NUM_Q; q++) share_sum = share_sum + SUM_W'(share[q]);
        leftover = (share_sum < SUM_W'(total)) ? CNT_W'(SUM_W'(total) - share_sum) : '0;
    end

    logic [SUM_W-1:0] out_sum;
    // Sum of the published allotments, used only by the check below.
    always_comb begin
        out_sum = '0;
        for (int q = 0; q < NUM_Q; q++) out_sum = out_sum + SUM_W'(mins[q*CNT_W +: CNT_W]);
    end

    // R9: the published allotments use the whole budget
    a_r9_split_conserves: assert property (@(posedge clk) disable iff (!rst_n)
        (share_sum <= SUM_W'(total)) |-> (out_sum == SUM_W'(total)));
endmodule

// File: rtl/dtq_thresh.sv
// Scales the free shared-cell count by a power-of-two alpha, using shifts only.
// Assumes code 7 is unity. Codes above the top value act as the top value.
module dtq_thresh
    import dtq_pkg::*;
#(
    parameter int CNT_W = 12,
    localparam int THR_W = CNT_W + ALPHA_TOP - ALPHA_UNITY
) (
    input  logic [CNT_W-1:0]   free_cells,
    input  logic [ALPHA_W-1:0] alpha_code,
    output logic [THR_W-1:0]   limit
);
    logic [ALPHA_W-1:0] code;

    // Choose the shift direction from the clamped code.
    always_comb begin
        code = alpha_clamp(alpha_code);
        if (code >= ALPHA_W'(ALPHA_UNITY))
            limit = THR_W'(free_cells) << (code - ALPHA_W'(ALPHA_UNITY));
        else
            limit = THR_W'(free_cells) >> (ALPHA_W'(ALPHA_UNITY) - code);
    end
endmodule

// File: rtl/dtq_qacct.sv
// Per-queue cell accounting, split into guaranteed and shared counts.
// Charges go to guaranteed cells first. Releases take shared cells first.
// Both counts saturate at zero. Assumes the admitted length was already checked.
module dtq_qacct #(
    parameter int CNT_W = 12,
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] min_cells,
    input  logic             take_en,
    input  logic [LEN_W-1:0] take_len,
    input  logic             rel_en,
    input  logic [LEN_W-1:0] rel_len,
    output logic [CNT_W-1:0] guar_q,
    output logic [CNT_W-1:0] shared_q
);
    logic [CNT_W-1:0] room, len_ext, rel_ext, gtake, stake, srel, grem, grel;

    // Split the charge and the release between the two regions.
    always_comb begin
        room    = (min_cells > guar_q) ? (min_cells - guar_q) : '0;
        len_ext = CNT_W'(take_len);
        rel_ext = CNT_W'(rel_len);
        gtake   = take_en ? ((len_ext < room) ? len_ext : room) : '0;
        stake   = take_en ? (len_ext - gtake) : '0;
        srel    = rel_en ? ((rel_ext < shared_q) ? rel_ext : shared_q) : '0;
        grem    = rel_ext - srel;
        grel    = rel_en ? ((grem < guar_q) ? grem : guar_q) : '0;
    end

    // Update both counts on each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            guar_q   <= '0;
            shared_q <= '0;
        end else begin
            guar_q   <= guar_q + gtake - grel;
            shared_q <= shared_q + stake - srel;
        end
    end

    // R3: shared use grows only once the guaranteed region is full
    a_r3_guar_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rel_en) && (shared_q > $past(shared_q))) |-> (guar_q == min_cells));
    // R3: guaranteed use never exceeds the allotment
    a_r3_guar_bound: assert property (@(posedge clk) disable iff (!rst_n)
        guar_q <= min_cells);
    // R8: a pure release never raises a count (no wrap)
    a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rel_en) && !$past(take_en)) |-> (guar_q <= $past(guar_q) && shared_q <= $past(shared_q)));
    // R8: guaranteed cells are returned only after the shared ones are gone
    a_r8_shared_first: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rel_en) && !$past(take_en) && (guar_q < $past(guar_q))) |-> (shared_q == '0));
endmodule

// File: rtl/dtq_admit.sv
// Admission controller for one shared egress pool serving NUM_Q queues.
// A request is judged against the current counts, and the decision is registered.
// Accepted cells and releases are applied on the same edge.
// Assumes configuration is stable outside reset, NUM_Q is a power of two,
// and LEN_W <= CNT_W.
module dtq_admit
    import dtq_pkg::*;
#(
    parameter int NUM_Q  = 4,
    parameter int CNT_W  = 12,
    parameter int LEN_W  = 6,
    parameter int FRAC_W = 8,
    localparam int QID_W = $clog2(NUM_Q),
    localparam int SUM_W = CNT_W + QID_W + 1,
    localparam int THR_W = CNT_W + ALPHA_TOP - ALPHA_UNITY
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CNT_W-1:0]         cfg_pool_cells,
    input  logic [CNT_W-1:0]         cfg_guar_total,
    input  logic [NUM_Q*FRAC_W-1:0]  cfg_guar_frac,
    input  logic [NUM_Q*ALPHA_W-1:0] cfg_alpha,
    input  logic                     enq_valid,
    input  logic [QID_W-1:0]         enq_qid,
    input  logic [LEN_W-1:0]         enq_len,
    input  logic                     rel_valid,
    input  logic [QID_W-1:0]         rel_qid,
    input  logic [LEN_W-1:0]         rel_len,
    output logic                     res_valid,
    output logic                     res_accept,
    output logic [NUM_Q*CNT_W-1:0]   occ_guar,
    output logic [NUM_Q*CNT_W-1:0]   occ_shared,
    output logic [CNT_W-1:0]         pool_free
);
    logic [NUM_Q*CNT_W-1:0] mins_flat;
    logic [CNT_W-1:0]       g_arr [NUM_Q];
    logic [CNT_W-1:0]       s_arr [NUM_Q];
    logic [CNT_W-1:0]       m_arr [NUM_Q];
    logic [ALPHA_W-1:0]     a_arr [NUM_Q];
    logic [SUM_W-1:0]       pool_used;
    logic [CNT_W-1:0]       free_cells, room, len_ext, need;
    logic [THR_W-1:0]       limit;
    logic                   fits, admit;

    dtq_guar_split #(.NUM_Q(NUM_Q), .CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_split (
        .clk   (clk),
        .rst_n (rst_n),
        .total (cfg_guar_total),
        .frac  (cfg_guar_frac),
        .mins  (mins_flat)
    );

    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        assign m_arr[q] = mins_flat[q*CNT_W +: CNT_W];
        assign a_arr[q] = cfg_alpha[q*ALPHA_W +: ALPHA_W];
        dtq_qacct #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_acct (
            .clk       (clk),
            .rst_n     (rst_n),
            .min_cells (m_arr[q]),
            .take_en   (admit && (enq_qid == QID_W'(q))),
            .take_len  (enq_len),
            .rel_en    (rel_valid && (rel_qid == QID_W'(q))),
            .rel_len   (rel_len),
            .guar_q    (g_arr[q]),
            .shared_q  (s_arr[q])
        );
        assign occ_guar[q*CNT_W +: CNT_W]   = g_arr[q];
        assign occ_shared[q*CNT_W +: CNT_W] = s_arr[q];
    end

    // Total shared use and the free shared cells that remain.
    always_comb begin
        pool_used = '0;
        for (int q = 0; q < NUM_Q; q++) pool_used = pool_used + SUM_W'(s_arr[q]);
        free_cells = (SUM_W'(cfg_pool_cells) > pool_used)
                   ? CNT_W'(SUM_W'(cfg_pool_cells) - pool_used) : '0;
    end
    assign pool_free = free_cells;

    dtq_thresh #(.CNT_W(CNT_W)) u_thresh (
        .free_cells (free_cells),
        .alpha_code (a_arr[enq_qid]),
        .limit      (limit)
    );

    // Shared cells the request needs, and whether all of its cells fit.
    always_comb begin
        room    = (m_arr[enq_qid] > g_arr[enq_qid]) ? (m_arr[enq_qid] - g_arr[enq_qid]) : '0;
        len_ext = CNT_W'(enq_len);
        need    = (len_ext > room) ? (len_ext - room) : '0;
        fits    = (need == '0) ||
                  ((need <= free_cells) && ((THR_W'(s_arr[enq_qid]) + THR_W'(need)) <= limit));
        admit   = enq_valid && fits;
    end

    // Register the decision for the cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_accept <= 1'b0;
        end else begin
            res_valid  <= enq_valid;
            res_accept <= admit;
        end
    end

    // R2: every request yields a decision on the next cycle
    a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        enq_valid |=> res_valid);
    // R2: no decision without a request
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !enq_valid |=> !res_valid);
    // R5: a request beyond the scaled limit is dropped
    a_r5_over_limit_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && (need != '0) && ((THR_W'(s_arr[enq_qid]) + THR_W'(need)) > limit)) |=> !res_accept);
    // R5: shared use never exceeds the pool
    a_r5_pool_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pool_used <= SUM_W'(cfg_pool_cells));
    // R7: a drop leaves every count untouched
    a_r7_drop_no_charge: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_accept && !$past(rel_valid)) |-> ($stable(occ_guar) && $stable(occ_shared)));
endmodule

// File: tb/dtq_admit_tb.sv
// Scoreboard bench: the driver queues the expected decisions, and a monitor
// pops and compares them as results appear. Counts are checked against a
// reference model after every operation.
module dtq_admit_tb;
    localparam int NQ = 4;
    localparam int CW = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [CW-1:0]   cfg_pool_cells = '0;
    logic [CW-1:0]   cfg_guar_total = '0;
    logic [31:0]     cfg_guar_frac = '0;
    logic [15:0]     cfg_alpha = '0;
    logic            enq_valid = 1'b0;
    logic [1:0]      enq_qid = '0;
    logic [5:0]      enq_len = '0;
    logic            rel_valid = 1'b0;
    logic [1:0]      rel_qid = '0;
    logic [5:0]      rel_len = '0;
    logic            res_valid, res_accept;
    logic [NQ*CW-1:0] occ_guar, occ_shared;
    logic [CW-1:0]   pool_free;

    int checks = 0;
    int errors = 0;
    int mn [NQ];
    int g  [NQ];
    int s  [NQ];
    int al [NQ];
    int pool;
    bit    exp_acc [$];
    string exp_tag [$];

    always #10 clk = ~clk;

    dtq_admit u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_pool_cells(cfg_pool_cells),
        .cfg_guar_total(cfg_guar_total), .cfg_guar_frac(cfg_guar_frac),
        .cfg_alpha(cfg_alpha), .enq_valid(enq_valid), .enq_qid(enq_qid),
        .enq_len(enq_len), .rel_valid(rel_valid), .rel_qid(rel_qid),
        .rel_len(rel_len), .res_valid(res_valid), .res_accept(res_accept),
        .occ_guar(occ_guar), .occ_shared(occ_shared), .pool_free(pool_free)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int used_cells();
        int u = 0;
        for (int q = 0; q < NQ; q++) u += s[q];
        return u;
    endfunction

    // Reference rule for admission (R5, R6, R7)
    function automatic bit model_fits(input int q, input int len);
        int room, need, free, a, lim;
        room = (mn[q] > g[q]) ? mn[q] - g[q] : 0;
        need = (len > room) ? len - room : 0;
        if (need == 0) return 1'b1;
        free = pool - used_cells();
        if (free < 0) free = 0;
        a = (al[q] > 10) ? 10 : al[q];
        lim = (a >= 7) ? (free << (a - 7)) : (free >> (7 - a));
        return (need <= free) && (s[q] + need <= lim);
    endfunction

    task automatic check_occ(input string tag);
        for (int q = 0; q < NQ; q++) begin
            chk({tag, " guar"}, int'(occ_guar[q*CW +: CW]), g[q]);
            chk({tag, " shared"}, int'(occ_shared[q*CW +: CW]), s[q]);
        end
        chk({tag, " free"}, int'(pool_free), pool - used_cells());
    endtask

    // Apply a configuration under reset and check the reset state (R1, R9 allotments)
    task automatic restart(input int p, input int tot, input int f0, input int f1,
                           input int f2, input int f3, input int a0, input int a1,
                           input int a2, input int a3);
        int f [NQ];
        int sum;
        f = '{f0, f1, f2, f3};
        al = '{a0, a1, a2, a3};
        @(negedge clk);
        rst_n = 1'b0;
        cfg_pool_cells = CW'(p);
        cfg_guar_total = CW'(tot);
        cfg_guar_frac = {8'(f3), 8'(f2), 8'(f1), 8'(f0)};
        cfg_alpha = {4'(a3), 4'(a2), 4'(a1), 4'(a0)};
        pool = p;
        sum = 0;
        for (int q = 0; q < NQ; q++) begin
            mn[q] = (tot * f[q]) / 256;
            sum += mn[q];
            g[q] = 0;
            s[q] = 0;
        end
        mn[0] += tot - sum;
        repeat (3) @(negedge clk);
        check_occ("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 res_valid after reset", int'(res_valid), 0);
        check_occ("R1 after reset");
    endtask

    // Drive one cycle of enqueue and/or release, then check all counts
    task automatic do_op(input bit ev, input int eq, input int el, input bit rv,
                         input int rq, input int rl, input string tag);
        int gt, st, sr, gr, room;
        bit acc;
        @(negedge clk);
        enq_valid = ev; enq_qid = 2'(eq); enq_len = 6'(el);
        rel_valid = rv; rel_qid = 2'(rq); rel_len = 6'(rl);
        gt = 0; st = 0; sr = 0; gr = 0;
        if (ev) begin
            acc = model_fits(eq, el);
            exp_acc.push_back(acc);
            exp_tag.push_back(tag);
            if (acc) begin
                room = (mn[eq] > g[eq]) ? mn[eq] - g[eq] : 0;
                gt = (el < room) ? el : room;
                st = el - gt;
            end
        end
        if (rv) begin
            sr = (rl < s[rq]) ? rl : s[rq];
            gr = ((rl - sr) < g[rq]) ? (rl - sr) : g[rq];
        end
        if (ev) begin g[eq] += gt; s[eq] += st; end
        if (rv) begin g[rq] -= gr; s[rq] -= sr; end
        @(negedge clk);
        enq_valid = 1'b0;
        rel_valid = 1'b0;
        check_occ(tag);
    endtask

    // Monitor: compare each decision with the scoreboard (R2)
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            checks++;
            if (exp_acc.size() == 0) begin
                errors++;
                $display("FAIL R2 unexpected decision actual=1 expected=0");
            end else begin
                bit e;
                string t;
                e = exp_acc.pop_front();
                t = exp_tag.pop_front();
                if (res_accept !== e) begin
                    errors++;
                    $display("FAIL %s decision actual=%0d expected=%0d", t, res_accept, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // Mixed allotments: q0 42 (25 + 17 rounding cells), q1 25, q2 33, q3 0
        restart(256, 100, 64, 64, 85, 0, 7, 7, 7, 7);
        do_op(1, 0, 42, 0, 0, 0, "R9 q0 gets remainder");
        do_op(1, 0, 1, 0, 0, 0, "R3 shared after guaranteed");
        do_op(1, 2, 40, 0, 0, 0, "R4 spill into shared");
        do_op(1, 1, 25, 0, 0, 0, "R9 floor share");
        do_op(1, 1, 1, 0, 0, 0, "R3 q1 shared");
        do_op(1, 3, 63, 0, 0, 0, "R5 no allotment");
        do_op(1, 3, 63, 0, 0, 0, "R5 second burst");
        do_op(1, 3, 63, 0, 0, 0, "R7 over limit drop");
        do_op(0, 0, 0, 1, 2, 10, "R8 shared first");
        do_op(0, 0, 0, 1, 0, 63, "R8 clamp at zero");
        do_op(1, 1, 5, 1, 3, 63, "R8 enqueue with release");
        do_op(1, 1, 2, 1, 1, 1, "R8 same queue both");
        @(negedge clk);
        chk("R2 scoreboard drained", exp_acc.size(), 0);

        // No guarantees; alphas 1, 2, 1/16, clamped 8
        restart(256, 0, 0, 0, 0, 0, 7, 8, 3, 12);
        for (int i = 0; i < 10; i++) do_op(1, 0, 16, 0, 0, 0, "R10 fill q0");
        chk("R10 half pool", int'(occ_shared[0 +: CW]), 128);
        do_op(1, 0, 1, 0, 0, 0, "R10 drop past half");
        for (int i = 0; i < 10; i++) do_op(1, 1, 16, 0, 0, 0, "R6 alpha two");
        do_op(1, 2, 2, 0, 0, 0, "R6 alpha sixteenth");
        do_op(1, 2, 1, 0, 0, 0, "R6 sixteenth drop");
        do_op(1, 3, 31, 0, 0, 0, "R5 need above free");
        do_op(1, 3, 20, 0, 0, 0, "R5 fits free");

        // Single queue with code 12, which acts as 8
        restart(256, 0, 0, 0, 0, 0, 7, 7, 7, 12);
        for (int i = 0; i < 20; i++) do_op(1, 3, 16, 0, 0, 0, "R6 clamp fill");
        chk("R6 clamped code limit", int'(occ_shared[3*CW +: CW]), 240);
        @(negedge clk);
        chk("R2 scoreboard drained", exp_acc.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule